// File: doc/BRIEF.md
# Programmable Token Ring Oscillator Model

This block is a cycle-based, synthesizable model of a self-timed ring built from Muller C-element stages. A fast simulation clock drives it. On every tick each active stage looks at the ring state from the previous tick. A stage hands its token forward when the stage after it holds a bubble, and each stage fires at most once per tick. The model leaves out analog delay and the drafting-distance timing effect. It keeps the property that matters for frequency planning: over a long enough window, the output rate is set by the numbers of tokens and bubbles, not by where they start.

The ring is configured by two words. A token word presets every stage to a token or a bubble. A small length code bypasses the highest-numbered stages, which shortens the ring. Software can change the configuration at run time with a load strobe. A configuration with an odd token count, no token, or no bubble is refused. A stop input freezes the ring without losing any token. The ring output is the phase of stage 0. It flips each time a token arrives in that stage.

Top module: `tro_ring_osc`

## Requirements
- R1: Bit i of `tok_word` presets stage i, where 1 means a token and 0 means a bubble. While `rst` is high with a legal configuration, the ring loads these bits and `ring_out` is 0. With tokens in stages 0 and 1 of an 11-stage ring, `ring_out` goes to 1 after the 10th tick following reset.
- R2: If `rst` is high while the configuration words are illegal, the ring loads the built-in default instead. The default has all stages active and tokens in stages 0 to 3.
- R3: A token moves from stage i to the next active stage only when that stage held a bubble on the previous tick. Otherwise every stage keeps its value, and the number of tokens never changes. In the R1 case, `ring_out` is 1 after ticks 10 and 11 and returns to 0 after tick 12.
- R4: `ring_out` flips once per token arrival in stage 0. With active length L, NT tokens and NB bubbles, once the ring has settled, any 8·L consecutive ticks give exactly 8·min(NT,NB) flips.
- R5: Two loadings with the same token and bubble totals give the same flip count in the settled window.
- R6: The active length is NSTAGES minus `len_code`. Stages at or above that length are bypassed and hold bubbles, and the token-word bits for those stages are ignored.
- R7: A configuration is legal only when the active stages hold an even number of tokens, at least two, and at least one bubble. A load with an illegal configuration is ignored and the ring keeps running unchanged.
- R8: While `stop` is high, no stage and no output changes. After `stop` is released, the ring continues at its previous rate with no token lost.
- R9: A load with a legal configuration restarts the ring from the new words, and `ring_out` reads 0 one edge later.
- R10: With `len_code` 0 all 11 stages are active and only the token mix sets the rate. 10 tokens with 1 bubble flip less often than 6 tokens with 5 bubbles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Simulation tick clock |
| rst | input | 1 | Synchronous active-high reset; loads the words or the default |
| stop | input | 1 | Freeze the ring while high |
| load | input | 1 | One-cycle strobe to apply new configuration words |
| tok_word | input | NSTAGES | Per-stage preset, 1 = token |
| len_code | input | LEN_CODE_W | Number of bypassed top stages |
| ring_out | output | 1 | Phase of stage 0 |

## Verification
Each tick moves tokens through one register stage. A token arrival is therefore visible on `ring_out` at the first falling edge after the rising edge that moved it, and the bench samples single-tick results at exactly that falling edge. A reload shows its cleared output one edge after the strobe, and a stop shows no change from the first frozen edge on. Rate results only hold once the ring has settled. For that reason the bench waits 6·L ticks after every reset or reload, then counts flips over exactly 8·L ticks, so the expected count of 8·min(NT,NB) is exact. After a stop is released it counts with no wait, because the frozen state was already settled.

// File: rtl/tro_pkg.sv
package tro_pkg;

    // Widest ring the helper functions can handle.
    localparam int unsigned TRO_MAX_STAGES = 32;
    // Width of the stored active-length value.
    localparam int unsigned TRO_LEN_W      = 8;

    // What the ring does on the next edge.
    typedef enum logic [1:0] {
        RA_HOLD = 2'd0,
        RA_STEP = 2'd1,
        RA_LOAD = 2'd2
    } ring_act_e;

    // A full ring configuration: preset tokens and active length.
    typedef struct packed {
        logic [TRO_MAX_STAGES-1:0] tok;
        logic [TRO_LEN_W-1:0]      len;
    } ring_cfg_t;

    // Mask with the lowest len bits set.
    function automatic logic [TRO_MAX_STAGES-1:0] span_mask(input logic [TRO_LEN_W-1:0] len);
        logic [TRO_MAX_STAGES-1:0] m;
        for (int i = 0; i < TRO_MAX_STAGES; i++) begin
            m[i] = (TRO_LEN_W'(i) < len);
        end
        return m;
    endfunction

    // Count of set bits.
    function automatic int ones_in(input logic [TRO_MAX_STAGES-1:0] v);
        int n;
        n = 0;
        for (int i = 0; i < TRO_MAX_STAGES; i++) begin
            n += int'(v[i]);
        end
        return n;
    endfunction

    // Legal mix: even token count of at least two, and at least one bubble.
    function automatic logic mix_ok(input ring_cfg_t c);
        int nt;
        nt = ones_in(c.tok & span_mask(c.len));
        return (nt >= 2) && (nt % 2 == 0) && (nt < int'(c.len));
    endfunction

endpackage

// File: rtl/tro_cfg_eval.sv
module tro_cfg_eval
    import tro_pkg::*;
#(
    parameter int unsigned NSTAGES      = 11,
    parameter int unsigned LEN_CODE_W   = 3,
    parameter logic [31:0] DEF_TOK      = 32'h0000_000F,
    parameter int unsigned DEF_LEN_CODE = 0
) (
    input  logic [NSTAGES-1:0]    tok_word,
    input  logic [LEN_CODE_W-1:0] len_code,
    output ring_cfg_t             word_cfg,
    output ring_cfg_t             def_cfg,
    output logic                  word_ok
);

    logic [TRO_MAX_STAGES-1:0] word_ext;
    logic [TRO_LEN_W-1:0]      word_len;
    logic [TRO_LEN_W-1:0]      def_len;

    always_comb begin
        word_ext                = '0;
        word_ext[NSTAGES-1:0]   = tok_word;
    end

    assign word_len = TRO_LEN_W'(NSTAGES) - TRO_LEN_W'(len_code);
    assign def_len  = TRO_LEN_W'(NSTAGES) - TRO_LEN_W'(DEF_LEN_CODE);

    // Bits for bypassed stages are dropped here, so they never reach the ring.
    always_comb begin
        word_cfg.len = word_len;
        word_cfg.tok = word_ext & span_mask(word_len);
        def_cfg.len  = def_len;
        def_cfg.tok  = TRO_MAX_STAGES'(DEF_TOK) & span_mask(def_len);
    end

    assign word_ok = mix_ok(word_cfg);

endmodule

// File: rtl/tro_seq.sv
module tro_seq
    import tro_pkg::*;
#(
    parameter int unsigned NSTAGES = 11
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 stop,
    input  logic                 load,
    input  ring_cfg_t            word_cfg,
    input  ring_cfg_t            def_cfg,
    input  logic                 word_ok,
    output ring_act_e            act,
    output ring_cfg_t            load_cfg,
    output logic [TRO_LEN_W-1:0] len_q,
    output logic [NSTAGES-1:0]   span
);

    // Priority: reset, then a legal load, then stop, else advance.
    always_comb begin
        act      = RA_STEP;
        load_cfg = word_cfg;
        if (rst) begin
            act      = RA_LOAD;
            load_cfg = word_ok ? word_cfg : def_cfg;
        end else if (load && word_ok) begin
            act = RA_LOAD;
        end else if (stop) begin
            act = RA_HOLD;
        end
    end

    always_ff @(posedge clk) begin
        if (act == RA_LOAD) begin
            len_q <= load_cfg.len;
        end
    end

    for (genvar i = 0; i < NSTAGES; i++) begin : g_span
        assign span[i] = (TRO_LEN_W'(i) < len_q);
    end

endmodule

// File: rtl/tro_stage.sv
module tro_stage
    import tro_pkg::*;
(
    input  logic      clk,
    input  ring_act_e act,
    input  logic      active,
    input  logic      init_tok,
    input  logic      prev_tok,
    input  logic      next_tok,
    output logic      tok
);

    logic take;
    logic give;

    // C-element view: accept from behind into a bubble, release into a bubble ahead.
    assign take = active & prev_tok & ~tok;
    assign give = active & tok & ~next_tok;

    always_ff @(posedge clk) begin
        unique case (act)
            RA_LOAD: tok <= init_tok;
            RA_STEP: begin
                if (take) begin
                    tok <= 1'b1;
                end else if (give) begin
                    tok <= 1'b0;
                end
            end
            default: tok <= tok;
        endcase
    end

endmodule

// File: rtl/tro_tap.sv
module tro_tap
    import tro_pkg::*;
(
    input  logic      clk,
    input  ring_act_e act,
    input  logic      active,
    input  logic      prev_tok,
    input  logic      self_tok,
    output logic      ring_out
);

    logic arrive;

    assign arrive = active & prev_tok & ~self_tok;

    always_ff @(posedge clk) begin
        if (act == RA_LOAD) begin
            ring_out <= 1'b0;
        end else if (act == RA_STEP && arrive) begin
            ring_out <= ~ring_out;
        end
    end

endmodule

// File: rtl/tro_ring_osc.sv
module tro_ring_osc
    import tro_pkg::*;
#(
    parameter int unsigned NSTAGES      = 11,
    parameter int unsigned LEN_CODE_W   = 3,
    parameter int unsigned OUT_TAP      = 0,
    parameter logic [31:0] DEF_TOK      = 32'h0000_000F,
    parameter int unsigned DEF_LEN_CODE = 0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  stop,
    input  logic                  load,
    input  logic [NSTAGES-1:0]    tok_word,
    input  logic [LEN_CODE_W-1:0] len_code,
    output logic                  ring_out
);

    // Shortest ring the length code can select; the output tap must sit inside it.
    localparam int unsigned MIN_LEN = NSTAGES - ((1 << LEN_CODE_W) - 1);

    ring_cfg_t            word_cfg;
    ring_cfg_t            def_cfg;
    ring_cfg_t            load_cfg;
    logic                 word_ok;
    ring_act_e            act;
    logic [TRO_LEN_W-1:0] len_q;
    logic [TRO_LEN_W-1:0] tail_idx;
    logic [NSTAGES-1:0]   span;
    logic [NSTAGES-1:0]   tok_q;
    logic [NSTAGES-1:0]   prev_tok;
    logic [NSTAGES-1:0]   next_tok;
    logic                 tail_tok;
    logic                 unused_cfg;

    tro_cfg_eval #(
        .NSTAGES      (NSTAGES),
        .LEN_CODE_W   (LEN_CODE_W),
        .DEF_TOK      (DEF_TOK),
        .DEF_LEN_CODE (DEF_LEN_CODE)
    ) u_cfg (
        .tok_word (tok_word),
        .len_code (len_code),
        .word_cfg (word_cfg),
        .def_cfg  (def_cfg),
        .word_ok  (word_ok)
    );

    tro_seq #(
        .NSTAGES (NSTAGES)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .stop     (stop),
        .load     (load),
        .word_cfg (word_cfg),
        .def_cfg  (def_cfg),
        .word_ok  (word_ok),
        .act      (act),
        .load_cfg (load_cfg),
        .len_q    (len_q),
        .span     (span)
    );

    assign unused_cfg = ^{load_cfg.len, load_cfg.tok};

    // Last active stage: its output wraps back to stage 0 through the bypass mux.
    assign tail_idx = len_q - TRO_LEN_W'(1);

    always_comb begin
        tail_tok = 1'b0;
        for (int j = 0; j < NSTAGES; j++) begin
            if (TRO_LEN_W'(j) == tail_idx) begin
                tail_tok = tok_q[j];
            end
        end
    end

    for (genvar i = 0; i < NSTAGES; i++) begin : g_ring
        if (i == 0) begin : g_head
            assign prev_tok[i] = tail_tok;
        end else begin : g_body
            assign prev_tok[i] = tok_q[i-1];
        end

        assign next_tok[i] = (len_q == TRO_LEN_W'(i + 1)) ? tok_q[0]
                                                          : tok_q[(i + 1) % NSTAGES];

        tro_stage u_stage (
            .clk      (clk),
            .act      (act),
            .active   (span[i]),
            .init_tok (load_cfg.tok[i]),
            .prev_tok (prev_tok[i]),
            .next_tok (next_tok[i]),
            .tok      (tok_q[i])
        );
    end

    tro_tap u_tap (
        .clk      (clk),
        .act      (act),
        .active   (span[OUT_TAP]),
        .prev_tok (prev_tok[OUT_TAP]),
        .self_tok (tok_q[OUT_TAP]),
        .ring_out (ring_out)
    );

endmodule

// File: rtl/tro_ring_osc_chk.sv
module tro_ring_osc_chk
    import tro_pkg::*;
#(
    parameter int unsigned NSTAGES = 11,
    parameter int unsigned MIN_LEN = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 stop,
    input logic                 load,
    input logic                 word_ok,
    input logic [NSTAGES-1:0]   tok_q,
    input logic [TRO_LEN_W-1:0] len_q,
    input logic                 ring_out
);

    // R8: a stopped ring keeps every stage and its output.
    assert_stop_freeze_R8: assert property (@(posedge clk) disable iff (rst)
        (stop && !load) |=> ($stable(tok_q) && $stable(ring_out)));

    // R3: stepping and holding never create or destroy tokens.
    assert_token_keep_R3: assert property (@(posedge clk) disable iff (rst)
        (!load) |=> ($countones(tok_q) == $countones($past(tok_q))));

    // R6: bypassed stages stay empty.
    assert_idle_tail_R6: assert property (@(posedge clk) disable iff (rst)
        ((tok_q >> len_q) == '0));

    // R6: active length stays within the selectable range.
    assert_len_window_R6: assert property (@(posedge clk) disable iff (rst)
        (int'(len_q) >= int'(MIN_LEN) && int'(len_q) <= int'(NSTAGES)));

    // R7: the running ring always has a legal mix.
    assert_mix_legal_R7: assert property (@(posedge clk) disable iff (rst)
        ($countones(tok_q) >= 2 && ($countones(tok_q) % 2) == 0
         && $countones(tok_q) < int'(len_q)));

    // R7: a refused load leaves the active length alone.
    assert_reject_keep_R7: assert property (@(posedge clk) disable iff (rst)
        (load && !word_ok) |=> $stable(len_q));

    // R9: an accepted load clears the output on the next edge.
    assert_reload_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (load && word_ok) |=> !ring_out);

endmodule

bind tro_ring_osc tro_ring_osc_chk #(
    .NSTAGES (NSTAGES),
    .MIN_LEN (MIN_LEN)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .stop     (stop),
    .load     (load),
    .word_ok  (word_ok),
    .tok_q    (tok_q),
    .len_q    (len_q),
    .ring_out (ring_out)
);

// File: tb/tro_ring_osc_bench.sv
module tro_ring_osc_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stop = 1'b0;
    logic        load = 1'b0;
    logic [10:0] tok_word = 11'h003;
    logic [2:0]  len_code = 3'd0;
    logic        ring_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    tro_ring_osc u_tro_ring_osc (
        .clk      (clk),
        .rst      (rst),
        .stop     (stop),
        .load     (load),
        .tok_word (tok_word),
        .len_code (len_code),
        .ring_out (ring_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic [10:0] tw, input logic [2:0] lc);
        @(negedge clk);
        rst = 1'b1; load = 1'b0; stop = 1'b0;
        tok_word = tw; len_code = lc;
        tick(3);
        rst = 1'b0;
    endtask

    task automatic count_flips(input int n, output int c);
        logic prev;
        c = 0;
        prev = ring_out;
        repeat (n) begin
            @(negedge clk);
            if (ring_out !== prev) c++;
            prev = ring_out;
        end
    endtask

    task automatic rate_check(input string req, input int len, input int exp, output int c);
        tick(6 * len);
        count_flips(8 * len, c);
        chk(c == exp, req, c, exp);
    endtask

    task automatic pulse_load(input logic [10:0] tw, input logic [2:0] lc);
        tok_word = tw; len_code = lc; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    // R1 and R3: preset, output during reset, exact arrival ticks.
    task automatic test_reset_state();
        @(negedge clk);
        rst = 1'b1; tok_word = 11'h003; len_code = 3'd0;
        tick(2);
        chk(ring_out == 1'b0, "R1 output low in reset", int'(ring_out), 0);
        rst = 1'b0;
        tick(9);
        chk(ring_out == 1'b0, "R3 no arrival before tick 10", int'(ring_out), 0);
        tick(1);
        chk(ring_out == 1'b1, "R1 first arrival at tick 10", int'(ring_out), 1);
        tick(1);
        chk(ring_out == 1'b1, "R3 hold at tick 11", int'(ring_out), 1);
        tick(1);
        chk(ring_out == 1'b0, "R3 second arrival at tick 12", int'(ring_out), 0);
    endtask

    // R4 and R10: full-length ring, rate set by the mix.
    task automatic test_ratio();
        int hi, lo;
        do_reset(11'h03F, 3'd0);
        rate_check("R4 6T/5B rate", 11, 40, hi);
        do_reset(11'h3FF, 3'd0);
        rate_check("R10 10T/1B rate", 11, 8, lo);
        chk(lo < hi, "R10 fewer bubbles is slower", lo, hi);
    endtask

    // R5: same totals, different placement.
    task automatic test_same_totals();
        int a, b;
        do_reset(11'h00F, 3'd0);
        rate_check("R5 clustered 4T/7B", 11, 32, a);
        do_reset(11'h461, 3'd0);
        rate_check("R5 spread 4T/7B", 11, 32, b);
        chk(a == b, "R5 placement independent", b, a);
    endtask

    // R6: shortened rings ignore bits of bypassed stages.
    task automatic test_length();
        int c;
        do_reset(11'h703, 3'd3);
        rate_check("R6 length 8 with 2 tokens", 8, 16, c);
        do_reset(11'h7F3, 3'd7);
        rate_check("R6 length 4 with 2 tokens", 4, 16, c);
    endtask

    // R2 and R7: illegal words at reset and at load.
    task automatic test_bad_words();
        int c;
        do_reset(11'h000, 3'd0);
        rate_check("R2 default after illegal reset", 11, 32, c);
        do_reset(11'h03F, 3'd0);
        tick(66);
        pulse_load(11'h007, 3'd0);
        pulse_load(11'h0FF, 3'd3);
        pulse_load(11'h000, 3'd5);
        rate_check("R7 illegal loads ignored", 11, 40, c);
    endtask

    // R8: stop freezes and resumes with no loss.
    task automatic test_stop();
        int c;
        do_reset(11'h03F, 3'd0);
        tick(66);
        stop = 1'b1;
        count_flips(30, c);
        chk(c == 0, "R8 frozen while stopped", c, 0);
        stop = 1'b0;
        count_flips(88, c);
        chk(c == 40, "R8 rate after release", c, 40);
    endtask

    // R9: legal load restarts with new words.
    task automatic test_reload();
        int c;
        int guard;
        do_reset(11'h3FF, 3'd0);
        guard = 0;
        while (ring_out !== 1'b1 && guard < 200) begin
            tick(1);
            guard++;
        end
        chk(ring_out == 1'b1, "R9 output high before reload", int'(ring_out), 1);
        pulse_load(11'h03F, 3'd0);
        chk(ring_out == 1'b0, "R9 output cleared by reload", int'(ring_out), 0);
        rate_check("R9 new rate after reload", 11, 40, c);
    endtask

    initial begin
        test_reset_state();
        test_ratio();
        test_same_totals();
        test_length();
        test_bad_words();
        test_stop();
        test_reload();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule